// File: doc/BRIEF.md
# Offset Min-Sum Check Node Unit

This unit performs the check node update of a layered LDPC decoder for a check node of degree eight. Eight signed variable-to-check messages arrive together under a valid strobe. For each of the eight edges it returns a check-to-variable message. The sign of that message is the parity of the other seven input signs. Its magnitude is the smallest of the other seven input magnitudes, minus a fixed offset that stops at zero.

The unit does not search seven-way for each edge. Instead it finds the smallest magnitude, the second smallest and the position of the smallest, and then hands each edge one of those two values. The most negative input code is treated as the largest magnitude, so it does not wrap to zero. One register stage holds the results, and the output strobe follows the input strobe by one clock.

Top module: `cn_offset_minsum`

## Requirements
- R1: Each input is a Q-bit two's complement value (Q=6 by default, range -32..31). Its sign is bit Q-1, and its magnitude is its absolute value.
- R2: An input equal to the most negative code (-32 at Q=6) gets magnitude 2^(Q-1)-1 (31), never zero.
- R3: The sign of output j is the XOR of the signs of all inputs other than j.
- R4: The magnitude of output j is the smallest magnitude among the seven inputs other than j, minus OFFSET (default 1), floored at zero.
- R5: When several inputs share the smallest magnitude, every output gets that smallest magnitude (less the offset). This includes the output at the lowest such index.
- R6: An output whose magnitude is zero is the value 0 whatever its sign. Otherwise the output is +mag or -mag in two's complement.
- R7: All eight outputs are presented one clock after the cycle in which valid_in is high. They hold their values while valid_in is low.
- R8: valid_out is high exactly one clock after each cycle in which valid_in is high. A synchronous active-high reset clears valid_out and the outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Input messages valid this cycle |
| v2c_msg | input | 8*Q | Eight packed input messages; edge k occupies bits [k*Q +: Q] |
| valid_out | output | 1 | Output messages valid |
| c2v_msg | output | 8*Q | Eight packed output messages; edge k occupies bits [k*Q +: Q] |

## Verification
A wrong min1 index or a wrong min2 shows up in the same registered cycle. In that case the output at the smallest input's edge carries the minimum it should have excluded, or the other edges carry the runner-up. A bad sign parity flips every output sign together. A wrapped magnitude for the most negative code makes that edge look like the weakest input, so the other seven outputs collapse to zero. Every one of these faults is visible one clock after valid_in. The bench compares each output against a brute-force seven-way minimum over patterns that target these cases.

// File: rtl/cn_minsum_pkg.sv
package cn_minsum_pkg;
  localparam int DEG = 8;
  localparam int IDXW = $clog2(DEG);
endpackage

// File: rtl/cn_sign_mag.sv
module cn_sign_mag #(
  parameter int Q = 6
) (
  input  logic [Q-1:0] msg,
  output logic         sgn,
  output logic [Q-2:0] mag
);
  function automatic logic [Q-2:0] sat_abs(input logic [Q-1:0] v);
    logic [Q-1:0] neg;
    neg = ~v + 1'b1;
    if (!v[Q-1]) return v[Q-2:0];
    if (neg[Q-1]) return {(Q-1){1'b1}};
    return neg[Q-2:0];
  endfunction

  assign sgn = msg[Q-1];
  assign mag = sat_abs(msg);

  // R2
  always_comb begin
    most_neg_clamp_chk: assert (!(msg == {1'b1, {(Q-1){1'b0}}}) || mag == {(Q-1){1'b1}});
  end
endmodule

// File: rtl/cn_two_min.sv
module cn_two_min
  import cn_minsum_pkg::*;
#(
  parameter int MW = 5
) (
  input  logic [DEG-1:0][MW-1:0] mags,
  output logic [MW-1:0]          min1,
  output logic [MW-1:0]          min2,
  output logic [IDXW-1:0]        min1_idx
);
  always_comb begin
    min1 = mags[0];
    min2 = {MW{1'b1}};
    min1_idx = '0;
    for (int k = 1; k < DEG; k++) begin
      if (mags[k] < min1) begin
        min2 = min1;
        min1 = mags[k];
        min1_idx = IDXW'(k);
      end else if (mags[k] < min2) begin
        min2 = mags[k];
      end
    end
  end

  // R4
  always_comb begin
    min_order_chk: assert (min1 <= min2);
    min_idx_chk: assert (mags[min1_idx] == min1);
  end
endmodule

// File: rtl/cn_out_build.sv
module cn_out_build #(
  parameter int Q = 6,
  parameter int OFFSET = 1
) (
  input  logic         sgn,
  input  logic [Q-2:0] mag_raw,
  output logic [Q-1:0] msg
);
  localparam int MW = Q - 1;

  function automatic logic [MW-1:0] sub_sat(input logic [MW-1:0] m);
    if (int'(m) <= OFFSET) return '0;
    return m - MW'(OFFSET);
  endfunction

  function automatic logic [Q-1:0] to_twos(input logic s, input logic [MW-1:0] m);
    logic [Q-1:0] p;
    p = {1'b0, m};
    if (m == '0) return '0;
    return s ? (~p + 1'b1) : p;
  endfunction

  logic [MW-1:0] mag_off;
  assign mag_off = sub_sat(mag_raw);
  assign msg = to_twos(sgn, mag_off);

  // R6
  always_comb begin
    zero_no_sign_chk: assert (mag_off != '0 || msg == '0);
  end
endmodule

// File: rtl/cn_offset_minsum.sv
module cn_offset_minsum
  import cn_minsum_pkg::*;
#(
  parameter int Q = 6,
  parameter int OFFSET = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [DEG*Q-1:0] v2c_msg,
  output logic             valid_out,
  output logic [DEG*Q-1:0] c2v_msg
);
  localparam int MW = Q - 1;

  logic [DEG-1:0]          sgns;
  logic [DEG-1:0][MW-1:0]  mags;
  logic [MW-1:0]           min1, min2;
  logic [IDXW-1:0]         min1_idx;
  logic                    parity;
  logic [DEG*Q-1:0]        next_out;

  for (genvar k = 0; k < DEG; k++) begin : g_in
    cn_sign_mag #(.Q(Q)) u_sm (
      .msg (v2c_msg[k*Q +: Q]),
      .sgn (sgns[k]),
      .mag (mags[k])
    );
  end

  cn_two_min #(.MW(MW)) u_min (
    .mags     (mags),
    .min1     (min1),
    .min2     (min2),
    .min1_idx (min1_idx)
  );

  assign parity = ^sgns;

  for (genvar k = 0; k < DEG; k++) begin : g_out
    logic [MW-1:0] sel_mag;
    logic          out_sgn;
    assign sel_mag = (min1_idx == IDXW'(k)) ? min2 : min1;
    assign out_sgn = parity ^ sgns[k];
    cn_out_build #(.Q(Q), .OFFSET(OFFSET)) u_ob (
      .sgn     (out_sgn),
      .mag_raw (sel_mag),
      .msg     (next_out[k*Q +: Q])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      c2v_msg   <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) c2v_msg <= next_out;
    end
  end

  // R8
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(c2v_msg));
endmodule

// File: tb/test_cn_offset_minsum.sv
module test_cn_offset_minsum;
  localparam int Q = 6;
  localparam int OFF = 1;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, valid_in = 0;
  logic [N*Q-1:0] v2c = '0;
  logic valid_out;
  logic [N*Q-1:0] c2v;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cn_offset_minsum #(.Q(Q), .OFFSET(OFF)) i_cn_offset_minsum (
    .clk(clk), .rst(rst), .valid_in(valid_in), .v2c_msg(v2c),
    .valid_out(valid_out), .c2v_msg(c2v));

  function automatic int bench_mag(input int v);
    int a;
    a = (v < 0) ? -v : v;
    return (a > 31) ? 31 : a;
  endfunction

  function automatic int expect_out(input int vals[N], input int j);
    int m, s, r;
    m = 1000; s = 0;
    for (int k = 0; k < N; k++) begin
      if (k == j) continue;
      if (bench_mag(vals[k]) < m) m = bench_mag(vals[k]);
      if (vals[k] < 0) s ^= 1;
    end
    r = m - OFF;
    if (r < 0) r = 0;
    return s ? -r : r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int vals[N], input string req);
    @(negedge clk);
    for (int k = 0; k < N; k++) v2c[k*Q +: Q] = Q'(vals[k]);
    valid_in = 1;
    @(negedge clk);
    valid_in = 0;
    check("R8 valid_out", int'(valid_out), 1);
    for (int j = 0; j < N; j++)
      check(req, int'($signed(c2v[j*Q +: Q])), expect_out(vals, j));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v[N];
    int seed;
    seed = 7;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R8 reset valid_out", int'(valid_out), 0);
    check("R8 reset outputs", int'(c2v == '0), 1);

    // R3 R4 basic distinct magnitudes
    v = '{5, -3, 9, 12, -7, 4, 20, -15};
    run_vec(v, "R3/R4 distinct");
    // R5 ties at minimum
    v = '{6, -6, 6, 10, -6, 11, 12, 6};
    run_vec(v, "R5 tie");
    v = '{3, 3, 3, 3, 3, 3, 3, 3};
    run_vec(v, "R5 all equal");
    // R6 zeros and offset floor
    v = '{0, -1, 5, 8, -9, 2, 0, 7};
    run_vec(v, "R6 zeros");
    v = '{-1, -1, -1, -1, -1, -1, -1, -2};
    run_vec(v, "R6 negative floor");
    // R1 R2 most negative values
    v = '{-32, -32, -32, -32, -32, -32, -32, -32};
    run_vec(v, "R2 all most-negative");
    v = '{-32, 31, 30, -29, 31, 28, -32, 30};
    run_vec(v, "R1/R2 large");
    v = '{-32, 25, 25, 25, 25, 25, 25, 25};
    run_vec(v, "R2 most-negative not weakest");

    // R7 hold while valid low
    @(negedge clk);
    v2c = '1;
    @(negedge clk);
    check("R7 hold", int'($signed(c2v[0 +: Q])), expect_out(v, 0));
    check("R8 idle valid_out", int'(valid_out), 0);

    // sweep of pseudo-random vectors, R4 position of min at every edge
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N; k++) v[k] = (k == p) ? ((p % 2) ? -2 : 1) : 5 + k;
      run_vec(v, "R4 min position");
    end
    for (int t = 0; t < 2000; t++) begin
      for (int k = 0; k < N; k++) begin
        seed = seed * 1103515245 + 12345;
        v[k] = ((seed >>> 16) & 63) - 32;
      end
      run_vec(v, "R3/R4 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule